// File: doc/BRIEF.md
# Flash Block Protection Controller

This controller sits between access requesters and an embedded flash array. It enforces two protection bits on each flash block. The program-enable bit controls program and erase. The read-enable bit controls data reads. Every request carries a kind (read, execute, program or erase) and a block index. The controller either forwards it to the array through `flash_go` or refuses it. A refused data read returns a word of zeros to the requester. Instruction fetches are never refused. Each refusal sets a sticky status bit. That bit raises the interrupt only while the interrupt mask is set.

Software can only clear protection bits, and the cleared values live in a staged copy. A commit pulse copies the staged bits into non-volatile cells, and those cells can never be set again. A power-on reset reloads the staged copy from the non-volatile cells, so an uncommitted clear is undone by power cycling. A two-bit debug field enables the debug access port when it holds 2'b10. The port-enable output is sampled only during power-on reset. Committing a cleared field therefore closes the port at the next power-up and never earlier. Only the debug access port path is gated. The test access port is outside this block and is not touched.

Top module: `flash_guard`

## Requirements
- R1: After the non-volatile cells are initialised (`nv_rst_n` low) and a power-on reset (`por_n` low) ends, `pe_bits` and `re_bits` are all ones, `dbg_field` is 2'b10, `dap_en` is 1, and `viol_sts` and `irq` are 0.
- R2: A program (`req_kind`=2) or erase (`req_kind`=3) request to a block whose program-enable bit is 0 gives `flash_go`=0 in the same cycle.
- R3: A read request (`req_kind`=0) to a block whose read-enable bit is 0 gives `flash_go`=0 and `rd_data_out`=0. Any other request passes `rd_data_in` to `rd_data_out`.
- R4: An execute request (`req_kind`=1) gives `flash_go`=1 whatever the two bits of the block are.
- R5: The bit pair (program-enable, read-enable) selects the policy. (0,0) allows execute only. (1,0) allows program, erase and execute but refuses reads. (0,1) allows read and execute. (1,1) allows every kind.
- R6: A configuration write (`cfg_we`=1) ANDs `cfg_wdata` into the selected staged register: `cfg_sel`=0 for program-enable, 1 for read-enable, 2 for the debug field in bits [1:0]. Writing a 1 never sets a bit that is 0.
- R7: A power-on reset restores every staged bit that was cleared without a commit to its committed value.
- R8: A `commit` pulse copies the staged bits into the non-volatile cells. A bit committed as 0 stays 0 after every later power-on reset.
- R9: A refused request sets `viol_sts` at the next clock edge. `viol_sts` holds until a write with `cfg_sel`=3 and `cfg_wdata[0]`=1 clears it. `irq` equals `viol_sts` AND `irq_mask`.
- R10: `dap_en` changes only during power-on reset, where it takes the committed debug field equal to 2'b10. Once the cleared field is committed, `dap_en` stays 1 until the next power-on reset, then reads 0 for good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_rst_n | input | 1 | Active-low initialisation of the non-volatile cells to the open state |
| por_n | input | 1 | Active-low power-on reset, synchronous |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 read, 1 execute, 2 program, 3 erase |
| req_blk | input | BLK_W | Target block index |
| rd_data_in | input | DATA_W | Word returned by the flash array |
| flash_go | output | 1 | Request forwarded to the array |
| rd_data_out | output | DATA_W | Word returned to the requester, zero on refused reads |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 program-enable, 1 read-enable, 2 debug field, 3 status clear |
| cfg_wdata | input | NUM_BLOCKS | Configuration write data |
| commit | input | 1 | Copy staged bits into the non-volatile cells |
| irq_mask | input | 1 | Interrupt mask, 1 lets the violation through |
| pe_bits | output | NUM_BLOCKS | Staged program-enable bits |
| re_bits | output | NUM_BLOCKS | Staged read-enable bits |
| dbg_field | output | 2 | Staged debug field |
| dap_en | output | 1 | Debug access port enable |
| viol_sts | output | 1 | Sticky violation flag |
| irq | output | 1 | Violation interrupt |

## Verification
The request path is driven with all four kinds against blocks that hold each of the four bit pairs. This separates a decoder that swaps the two bits from one that mistreats execute or erase. Reads use distinct non-zero data words, so a refused read that leaks the array word differs from a zero fill. Write patterns that set bits back to 1, power-on resets with and without a commit, and a cleared debug field both before and after a power-up show apart the staged copy, the non-volatile copy and the sampled port enable.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_EXEC  = 2'd1,
      ACC_PROG  = 2'd2,
      ACC_ERASE = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      SEL_PE   = 2'd0,
      SEL_RE   = 2'd1,
      SEL_DBG  = 2'd2,
      SEL_STAT = 2'd3
   } cfg_sel_e;

   localparam logic [1:0] DBG_OPEN = 2'b10;
endpackage

// File: rtl/fg_store.sv
module fg_store
   import fg_pkg::*;
#(
   parameter int NUM_BLOCKS = 8
) (
   input  logic                  clk,
   input  logic                  nv_rst_n,
   input  logic                  por_n,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_sel,
   input  logic [NUM_BLOCKS-1:0] cfg_wdata,
   input  logic                  commit,
   output logic [NUM_BLOCKS-1:0] pe_q,
   output logic [NUM_BLOCKS-1:0] re_q,
   output logic [1:0]            dbg_q,
   output logic [1:0]            nv_dbg
);
   logic [NUM_BLOCKS-1:0] nv_pe, nv_re;

   // non-volatile cells: only the commit path and factory init write them
   always_ff @(posedge clk) begin
      if (!nv_rst_n) begin
         nv_pe  <= '1;
         nv_re  <= '1;
         nv_dbg <= DBG_OPEN;
      end else if (commit && por_n) begin
         nv_pe  <= pe_q;
         nv_re  <= re_q;
         nv_dbg <= dbg_q;
      end
   end

   // staged copy: reloaded on power-on, otherwise clear-only
   always_ff @(posedge clk) begin
      if (!por_n) begin
         pe_q  <= nv_pe;
         re_q  <= nv_re;
         dbg_q <= nv_dbg;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_PE:  pe_q  <= pe_q & cfg_wdata;
            SEL_RE:  re_q  <= re_q & cfg_wdata;
            SEL_DBG: dbg_q <= dbg_q & cfg_wdata[1:0];
            default: ;
         endcase
      end
   end

   AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> (((pe_q & ~$past(pe_q)) == '0) && ((re_q & ~$past(re_q)) == '0)
                        && ((dbg_q & ~$past(dbg_q)) == '0))); // R6
   AST_NV_MONO: assert property (@(posedge clk) disable iff (!nv_rst_n)
      $past(nv_rst_n) |-> (((nv_pe & ~$past(nv_pe)) == '0) && ((nv_re & ~$past(nv_re)) == '0))); // R8
endmodule

// File: rtl/fg_policy.sv
module fg_policy
   import fg_pkg::*;
#(
   parameter int NUM_BLOCKS = 8,
   parameter int DATA_W     = 32,
   localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  req_valid,
   input  logic [1:0]            req_kind,
   input  logic [BLK_W-1:0]      req_blk,
   input  logic [DATA_W-1:0]     rd_data_in,
   input  logic [NUM_BLOCKS-1:0] pe,
   input  logic [NUM_BLOCKS-1:0] re,
   output logic                  flash_go,
   output logic [DATA_W-1:0]     rd_data_out,
   output logic                  refuse
);
   localparam int SLOTS = 1 << BLK_W;

   // per-slot allow vectors, slots beyond NUM_BLOCKS allow nothing
   logic [SLOTS-1:0] ok_rd, ok_wr, ok_ex;
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_BLOCKS) begin : g_real
         assign ok_rd[i] = re[i];
         assign ok_wr[i] = pe[i];
         assign ok_ex[i] = 1'b1;
      end else begin : g_none
         assign ok_rd[i] = 1'b0;
         assign ok_wr[i] = 1'b0;
         assign ok_ex[i] = 1'b0;
      end
   end

   logic allow;
   always_comb begin
      case (req_kind)
         ACC_READ:  allow = ok_rd[req_blk];
         ACC_EXEC:  allow = ok_ex[req_blk];
         default:   allow = ok_wr[req_blk];
      endcase
      flash_go    = req_valid && allow;
      refuse      = req_valid && !allow;
      rd_data_out = (req_kind == ACC_READ && !allow) ? '0 : rd_data_in;
   end

   AST_EXEC_OK: assert property (@(posedge clk) disable iff (!por_n)
      (req_valid && req_kind == ACC_EXEC && 32'(req_blk) < NUM_BLOCKS) |-> flash_go); // R4
endmodule

// File: rtl/fg_debug.sv
module fg_debug
   import fg_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic [1:0] nv_dbg,
   output logic       dap_en
);
   // sampled only while power-on reset is held
   always_ff @(posedge clk) begin
      if (!por_n) dap_en <= (nv_dbg == DBG_OPEN);
   end

   AST_DAP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> $stable(dap_en)); // R10
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fg_pkg::*;
#(
   parameter int NUM_BLOCKS = 8,
   parameter int DATA_W     = 32,
   localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic                  clk,
   input  logic                  nv_rst_n,
   input  logic                  por_n,
   input  logic                  req_valid,
   input  logic [1:0]            req_kind,
   input  logic [BLK_W-1:0]      req_blk,
   input  logic [DATA_W-1:0]     rd_data_in,
   output logic                  flash_go,
   output logic [DATA_W-1:0]     rd_data_out,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_sel,
   input  logic [NUM_BLOCKS-1:0] cfg_wdata,
   input  logic                  commit,
   input  logic                  irq_mask,
   output logic [NUM_BLOCKS-1:0] pe_bits,
   output logic [NUM_BLOCKS-1:0] re_bits,
   output logic [1:0]            dbg_field,
   output logic                  dap_en,
   output logic                  viol_sts,
   output logic                  irq
);
   if (NUM_BLOCKS < 2 || NUM_BLOCKS > 64) begin : g_bad_blocks
      $error("flash_guard: NUM_BLOCKS must lie in 2..64");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("flash_guard: DATA_W must be positive");
   end

   logic [1:0] nv_dbg;
   logic       refuse;

   fg_store #(.NUM_BLOCKS(NUM_BLOCKS)) u_store (
      .clk(clk), .nv_rst_n(nv_rst_n), .por_n(por_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .commit(commit),
      .pe_q(pe_bits), .re_q(re_bits), .dbg_q(dbg_field), .nv_dbg(nv_dbg)
   );

   fg_policy #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_policy (
      .clk(clk), .por_n(por_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_blk(req_blk),
      .rd_data_in(rd_data_in), .pe(pe_bits), .re(re_bits),
      .flash_go(flash_go), .rd_data_out(rd_data_out), .refuse(refuse)
   );

   fg_debug u_debug (
      .clk(clk), .por_n(por_n), .nv_dbg(nv_dbg), .dap_en(dap_en)
   );

   // sticky violation flag, a new refusal wins over a clear
   logic stat_clr;
   assign stat_clr = cfg_we && cfg_sel == SEL_STAT && cfg_wdata[0];

   always_ff @(posedge clk) begin
      if (!por_n)        viol_sts <= 1'b0;
      else if (refuse)   viol_sts <= 1'b1;
      else if (stat_clr) viol_sts <= 1'b0;
   end

   assign irq = viol_sts && irq_mask;

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      refuse |=> viol_sts); // R9
   AST_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (req_valid && req_kind == ACC_READ && !flash_go) |-> (rd_data_out == '0)); // R3
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
   localparam int  NB = 8;
   localparam int  DW = 32;
   localparam int  BW = 3;
   localparam time CLK_P = 10;

   logic clk = 0, nv_rst_n = 0, por_n = 0;
   logic req_valid = 0, cfg_we = 0, commit = 0, irq_mask = 0;
   logic [1:0] req_kind = 0, cfg_sel = 0;
   logic [BW-1:0] req_blk = 0;
   logic [DW-1:0] rd_data_in = 0;
   logic [NB-1:0] cfg_wdata = 0;
   logic flash_go, dap_en, viol_sts, irq;
   logic [DW-1:0] rd_data_out;
   logic [NB-1:0] pe_bits, re_bits;
   logic [1:0] dbg_field;

   always #(CLK_P/2) clk = ~clk;

   flash_guard #(.NUM_BLOCKS(NB), .DATA_W(DW)) u0 (.*);

   int checks = 0, errors = 0;
   bit done = 0;
   logic          exp_go_q[$];
   logic [DW-1:0] exp_rd_q[$];
   string         tag_q[$];
   event          mon_ev;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected results as the design presents them
   initial forever begin
      @(mon_ev);
      #1;
      begin
         logic eg; logic [DW-1:0] er; string t;
         eg = exp_go_q.pop_front(); er = exp_rd_q.pop_front(); t = tag_q.pop_front();
         chk({t, " go"}, 64'(flash_go), 64'(eg));
         chk({t, " data"}, 64'(rd_data_out), 64'(er));
      end
   end

   // driver: presents one request and queues its expected result
   task automatic access(input logic [1:0] k, input int b, input logic [DW-1:0] d,
                         input logic eg, input string tag);
      @(negedge clk);
      req_valid = 1; req_kind = k; req_blk = BW'(b); rd_data_in = d;
      exp_go_q.push_back(eg);
      exp_rd_q.push_back((k == 2'd0 && !eg) ? '0 : d);
      tag_q.push_back(tag);
      ->mon_ev;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic cfg(input logic [1:0] s, input logic [NB-1:0] w);
      @(negedge clk);
      cfg_we = 1; cfg_sel = s; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic do_commit();
      @(negedge clk); commit = 1;
      @(negedge clk); commit = 0;
   endtask

   task automatic power_on();
      @(negedge clk); por_n = 0;
      repeat (2) @(negedge clk);
      por_n = 1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      nv_rst_n = 1;
      repeat (2) @(negedge clk);
      por_n = 1;
      @(negedge clk);
      // R1 open state after factory init and power-on
      chk("R1 pe", 64'(pe_bits), 64'hFF);
      chk("R1 re", 64'(re_bits), 64'hFF);
      chk("R1 dbg", 64'(dbg_field), 64'h2);
      chk("R1 dap", 64'(dap_en), 64'h1);
      chk("R1 viol", 64'(viol_sts), 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);
      access(2'd0, 3, 32'hA5A5_0001, 1, "R5 open read");
      access(2'd2, 3, 32'h0000_1111, 1, "R5 open prog");
      chk("R9 no viol when granted", 64'(viol_sts), 64'h0);

      // block3 -> (0,1), block5 -> (1,0), block6 -> (0,0)
      cfg(2'd0, 8'b1011_0111);
      cfg(2'd1, 8'b1001_1111);
      access(2'd0, 3, 32'h1234_5678, 1, "R5 (0,1) read");
      access(2'd2, 3, 32'h0000_0003, 0, "R2 (0,1) prog");
      access(2'd3, 3, 32'h0000_0004, 0, "R2 (0,1) erase");
      access(2'd1, 3, 32'h0000_0005, 1, "R4 (0,1) exec");
      access(2'd0, 5, 32'hDEAD_BEEF, 0, "R3 (1,0) read");
      access(2'd2, 5, 32'h0000_0006, 1, "R5 (1,0) prog");
      access(2'd3, 5, 32'h0000_0007, 1, "R5 (1,0) erase");
      access(2'd1, 6, 32'h0000_0008, 1, "R4 (0,0) exec");
      access(2'd0, 6, 32'hCAFE_F00D, 0, "R3 (0,0) read");
      access(2'd3, 6, 32'h0000_0009, 0, "R2 (0,0) erase");

      // R9 sticky flag and mask
      chk("R9 viol set", 64'(viol_sts), 64'h1);
      chk("R9 irq masked", 64'(irq), 64'h0);
      irq_mask = 1; #1;
      chk("R9 irq unmasked", 64'(irq), 64'h1);
      cfg(2'd3, 8'h00);
      chk("R9 zero write keeps flag", 64'(viol_sts), 64'h1);
      cfg(2'd3, 8'h01);
      chk("R9 w1c clears", 64'(viol_sts), 64'h0);
      chk("R9 irq drops", 64'(irq), 64'h0);

      // R6 writing ones cannot set
      cfg(2'd0, 8'hFF);
      chk("R6 pe no set", 64'(pe_bits), 64'hB7);
      cfg(2'd1, 8'hFF);
      chk("R6 re no set", 64'(re_bits), 64'h9F);
      access(2'd2, 3, 32'h0000_000A, 0, "R6 prog still refused");

      // R7 power-on undoes uncommitted clears
      power_on();
      chk("R7 pe restored", 64'(pe_bits), 64'hFF);
      chk("R7 re restored", 64'(re_bits), 64'hFF);
      access(2'd0, 5, 32'h0BAD_0001, 1, "R7 read open again");

      // R8 / R10 commit a protection and the debug lockout
      cfg(2'd0, 8'b1111_0111);
      cfg(2'd2, 8'h00);
      chk("R10 dbg staged cleared", 64'(dbg_field), 64'h0);
      do_commit();
      chk("R10 dap unchanged before power-up", 64'(dap_en), 64'h1);
      power_on();
      chk("R8 committed bit stays 0", 64'(pe_bits), 64'hF7);
      chk("R8 re untouched", 64'(re_bits), 64'hFF);
      chk("R10 dap off after power-up", 64'(dap_en), 64'h0);
      access(2'd2, 3, 32'h0000_000B, 0, "R8 prog refused after power-up");
      cfg(2'd2, 8'h02);
      cfg(2'd0, 8'hFF);
      do_commit();
      power_on();
      chk("R10 dbg cannot return", 64'(dbg_field), 64'h0);
      chk("R10 dap stays off", 64'(dap_en), 64'h0);
      chk("R8 pe cannot return", 64'(pe_bits), 64'hF7);

      repeat (2) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule